// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is one programmable event counter for a core's performance-monitoring logic. Every clock cycle it receives a small per-cycle occurrence count for some hardware event, together with the current privilege level and a flag that says whether execution is inside a transactional memory region. A configuration word decides how that count is qualified. The qualifiers are user and kernel enables, a threshold, invert, edge detect, a transactional-only filter and a checkpoint option that discards increments made inside a transaction that later aborts.

Depending on the configuration, the counter either accumulates the raw occurrence count or steps by one in each qualifying cycle. It can be read and preset through a narrow register port. When it wraps past all ones it raises a sticky overflow flag, which software clears by writing a one. A configuration that asks for edge detection with a zero threshold is illegal. It freezes the counter and raises an error bit.

Top module: `qual_event_counter`

## Requirements
- R1: After reset the configuration word, the counter and the status word all read as zero.
- R2: With threshold 0, invert off and edge off, each enabled cycle adds the raw 4-bit occurrence count (0 to 15) to the counter.
- R3: With a nonzero threshold (configuration bits 15:8), an enabled cycle adds one when the occurrence count is greater than or equal to the threshold, and adds nothing otherwise.
- R4: Invert (configuration bit 2) makes the counter step by one in the cycles where the condition is absent: occurrence count zero when the threshold is 0, count below the threshold otherwise.
- R5: Edge detect (configuration bit 3) with a threshold of 1 or more adds one only in the first cycle of each run of qualifying cycles.
- R6: Edge detect combined with a threshold of 0 sets status bit 1 and freezes the counter until a legal configuration is written.
- R7: The counter holds its value while the global enable is low. Privilege level 0 counts only with the kernel enable (bit 1) set. Levels 1 to 3 count only with the user enable (bit 0) set.
- R8: With the transaction-only flag (bit 4) set, the counter advances only in cycles where the in-transaction input is high.
- R9: With the checkpoint flag (bit 5) set, the counter value present when the in-transaction input rises is saved. An abort restores that value on the next edge, even if an increment falls in the same cycle. A commit discards the saved value, so a later abort has no effect. With bit 5 clear, an abort leaves the counter unchanged.
- R10: A wrap of the 48-bit counter past all ones sets status bit 0. The bit stays set until a write of 1 to status bit 0. A wrap in the same cycle as that clearing write leaves the bit set.
- R11: Register address 0 holds the configuration. Only bits 15:8 and 5:0 are stored, and all other bits read as 0. Address 1 reads the counter, and a write there presets it, winning over an increment or restore in that cycle. Address 2 reads the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Master count enable |
| eventCount | input | 4 | Occurrences of the event in this cycle |
| privLevel | input | 2 | Current privilege level, 0 is kernel |
| inTxn | input | 1 | Execution is inside a transactional region |
| txnAbort | input | 1 | Transaction abort pulse |
| txnCommit | input | 1 | Transaction commit pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 48 | Register write data |
| regRdData | output | 48 | Register read data for regAddr, combinational |

## Verification
Two pairs of functions can fall in one cycle. An abort can coincide with a live increment, and a counter wrap can coincide with the write that clears the overflow bit. The bench provokes the first by holding a nonzero event count in the abort cycle and then expects exactly the saved entry value. It provokes the second by presetting the counter to all ones and issuing the clearing write in the very cycle of the wrap, then expects the flag to remain set. A preset issued during an increment is judged the same way, by reading back the written value.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int EVT_W = 4;
  localparam int THR_W = 8;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_KEEP = 16'hFF3F;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic [THR_W-1:0] thresh;
    logic [1:0]       spare;
    logic             txCkpt;
    logic             txOnly;
    logic             edgeEn;
    logic             invert;
    logic             kernEn;
    logic             userEn;
  } cfg_t;

  typedef struct packed {
    logic             step;
    logic [EVT_W-1:0] amount;
    logic             save;
    logic             restore;
  } strobe_t;
endpackage

// File: rtl/qec_ctrl.sv
module qec_ctrl
  import qec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             globalEn,
  input  logic [EVT_W-1:0] eventCount,
  input  logic [1:0]       privLevel,
  input  logic             inTxn,
  input  logic             txnAbort,
  input  logic             txnCommit,
  output cfg_t             cfgOut,
  output logic             cfgErr,
  output strobe_t          strobes
);
  cfg_t cfgQ;
  logic errQ;
  logic prevQual;
  logic prevInTxn;
  logic ckptValid;

  logic threshZero;
  logic meetsThresh;
  logic hit;
  logic qual;
  logic risePulse;
  logic rawMode;
  logic privOk;
  logic txOk;
  logic countOn;
  logic stepBit;

  always_comb begin
    threshZero  = (cfgQ.thresh == '0);
    meetsThresh = ({{(THR_W-EVT_W){1'b0}}, eventCount} >= cfgQ.thresh);
    hit         = threshZero ? (|eventCount) : meetsThresh;
    qual        = hit ^ cfgQ.invert;
    risePulse   = qual & ~prevQual;
    rawMode     = threshZero & ~cfgQ.invert & ~cfgQ.edgeEn;
    privOk      = (privLevel == 2'd0) ? cfgQ.kernEn : cfgQ.userEn;
    txOk        = ~cfgQ.txOnly | inTxn;
    countOn     = globalEn & privOk & txOk & ~errQ;
    if (rawMode)          stepBit = |eventCount;
    else if (cfgQ.edgeEn) stepBit = risePulse;
    else                  stepBit = qual;
    strobes.step    = countOn & stepBit;
    strobes.amount  = rawMode ? eventCount : EVT_W'(1);
    strobes.save    = inTxn & ~prevInTxn;
    strobes.restore = txnAbort & cfgQ.txCkpt & ckptValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ      <= '0;
      errQ      <= 1'b0;
      prevQual  <= 1'b0;
      prevInTxn <= 1'b0;
      ckptValid <= 1'b0;
    end else begin
      if (cfgWr) begin
        cfgQ <= cfg_t'(cfgData & CFG_KEEP);
        errQ <= cfgData[3] & (cfgData[15:8] == '0);
      end
      prevQual  <= qual;
      prevInTxn <= inTxn;
      if (txnAbort || txnCommit) ckptValid <= 1'b0;
      else if (strobes.save)     ckptValid <= 1'b1;
    end
  end

  assign cfgOut = cfgQ;
  assign cfgErr = errQ;

  assert_no_step_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !strobes.step);

  assert_err_freezes_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !strobes.step);

  assert_restore_needs_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |-> txnAbort);
endmodule

// File: rtl/qec_datapath.sv
module qec_datapath
  import qec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic             cntWr,
  input  logic             ovfClr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfFlag
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] ckptQ;
  logic             ovfQ;
  logic [CNT_W:0]   sum;
  logic             wrapNow;

  always_comb begin
    sum     = {1'b0, cntQ} + {{(CNT_W+1-EVT_W){1'b0}}, strobes.amount};
    wrapNow = strobes.step & ~cntWr & ~strobes.restore & sum[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      ckptQ <= '0;
      ovfQ  <= 1'b0;
    end else begin
      if (cntWr)                cntQ <= wrData;
      else if (strobes.restore) cntQ <= ckptQ;
      else if (strobes.step)    cntQ <= sum[CNT_W-1:0];
      if (strobes.save) ckptQ <= cntQ;
      if (wrapNow)      ovfQ <= 1'b1;
      else if (ovfClr)  ovfQ <= 1'b0;
    end
  end

  assign cntVal  = cntQ;
  assign ovfFlag = ovfQ;

  assert_restore_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.restore && !cntWr) |=> (cntQ == $past(ckptQ)));

  assert_preset_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (cntQ == $past(wrData)));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.restore && !cntWr) |=> $stable(cntQ));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !ovfClr) |=> ovfQ);
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
  import qec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic [3:0]       eventCount,
  input  logic [1:0]       privLevel,
  input  logic             inTxn,
  input  logic             txnAbort,
  input  logic             txnCommit,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData
);
  localparam int PAD_CFG  = CNT_W - CFG_W;
  localparam int PAD_STAT = CNT_W - 2;

  cfg_t             cfgCur;
  logic             cfgErr;
  strobe_t          strobes;
  logic [CNT_W-1:0] cntVal;
  logic             ovfFlag;
  logic             cfgWr;
  logic             cntWr;
  logic             ovfClr;

  assign cfgWr  = regWrEn & (regAddr == ADDR_CFG);
  assign cntWr  = regWrEn & (regAddr == ADDR_CNT);
  assign ovfClr = regWrEn & (regAddr == ADDR_STAT) & regWrData[0];

  qec_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWr),
    .cfgData    (regWrData[CFG_W-1:0]),
    .globalEn   (globalEn),
    .eventCount (eventCount),
    .privLevel  (privLevel),
    .inTxn      (inTxn),
    .txnAbort   (txnAbort),
    .txnCommit  (txnCommit),
    .cfgOut     (cfgCur),
    .cfgErr     (cfgErr),
    .strobes    (strobes)
  );

  qec_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cntWr   (cntWr),
    .ovfClr  (ovfClr),
    .wrData  (regWrData),
    .cntVal  (cntVal),
    .ovfFlag (ovfFlag)
  );

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdData = {{PAD_CFG{1'b0}}, cfgCur};
      ADDR_CNT:  regRdData = cntVal;
      ADDR_STAT: regRdData = {{PAD_STAT{1'b0}}, cfgErr, ovfFlag};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: tb/qual_event_counter_bench.sv
`timescale 1ns/1ps
module qual_event_counter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b0;
  logic [3:0]  eventCount = '0;
  logic [1:0]  privLevel = '0;
  logic        inTxn = 1'b0;
  logic        txnAbort = 1'b0;
  logic        txnCommit = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [47:0] regWrData = '0;
  logic [47:0] regRdData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  qual_event_counter u_qual_event_counter (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .eventCount(eventCount),
    .privLevel(privLevel), .inTxn(inTxn), .txnAbort(txnAbort), .txnCommit(txnCommit),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  // {req[31:28], cfg[27:12], priv[11:10], inTxn[9], evt[8:5], expected[4:0]}
  localparam logic [31:0] VEC [0:15] = '{
    {4'd2,  16'h0001, 2'd3, 1'b0, 4'd7,  5'd7},   // R2 raw, user level
    {4'd2,  16'h0002, 2'd0, 1'b0, 4'd15, 5'd15},  // R2 raw, kernel level
    {4'd7,  16'h0001, 2'd0, 1'b0, 4'd5,  5'd0},   // R7 user-only at level 0
    {4'd7,  16'h0002, 2'd2, 1'b0, 4'd5,  5'd0},   // R7 kernel-only at level 2
    {4'd7,  16'h0000, 2'd1, 1'b0, 4'd9,  5'd0},   // R7 no enables
    {4'd3,  16'h0403, 2'd1, 1'b0, 4'd4,  5'd1},   // R3 equal to threshold
    {4'd3,  16'h0403, 2'd1, 1'b0, 4'd3,  5'd0},   // R3 below threshold
    {4'd3,  16'h0403, 2'd1, 1'b0, 4'd15, 5'd1},   // R3 above threshold adds one
    {4'd3,  16'hFF03, 2'd1, 1'b0, 4'd15, 5'd0},   // R3 threshold 255
    {4'd4,  16'h0007, 2'd1, 1'b0, 4'd0,  5'd1},   // R4 invert, idle event
    {4'd4,  16'h0007, 2'd1, 1'b0, 4'd3,  5'd0},   // R4 invert, busy event
    {4'd4,  16'h0407, 2'd1, 1'b0, 4'd3,  5'd1},   // R4 invert below threshold
    {4'd8,  16'h0013, 2'd1, 1'b0, 4'd6,  5'd0},   // R8 outside transaction
    {4'd8,  16'h0013, 2'd1, 1'b1, 4'd6,  5'd6},   // R8 inside transaction
    {4'd5,  16'h020B, 2'd1, 1'b0, 4'd3,  5'd1},   // R5 rising edge
    {4'd6,  16'h000B, 2'd1, 1'b0, 4'd5,  5'd0}    // R6 illegal edge config
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [47:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [47:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic step(input logic [3:0] evt, input logic tx, input logic ab, input logic cm);
    globalEn = 1'b1; privLevel = 2'd1; eventCount = evt; inTxn = tx;
    txnAbort = ab; txnCommit = cm;
    @(negedge clk);
    globalEn = 1'b0; eventCount = '0; txnAbort = 1'b0; txnCommit = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] v;
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 cfg", v, 48'h0);
    rd(2'd1, v); check("R1 counter", v, 48'h0);
    rd(2'd2, v); check("R1 status", v, 48'h0);

    // table walk
    for (int i = 0; i < 16; i++) begin
      string tag;
      e = VEC[i];
      wr(2'd0, {32'h0, e[27:12]});
      wr(2'd1, 48'h0);
      globalEn = 1'b1; privLevel = e[11:10]; inTxn = e[9]; eventCount = e[8:5];
      @(negedge clk);
      globalEn = 1'b0; eventCount = '0; inTxn = 1'b0;
      rd(2'd1, v);
      tag = $sformatf("R%0d vector %0d", e[31:28], i);
      check(tag, v, {43'h0, e[4:0]});
    end

    // R5 two runs of qualifying cycles
    wr(2'd0, 48'h020B); wr(2'd1, 48'h0);
    step(4'd3, 0, 0, 0); step(4'd3, 0, 0, 0); step(4'd3, 0, 0, 0); step(4'd3, 0, 0, 0);
    step(4'd0, 0, 0, 0); step(4'd3, 0, 0, 0); step(4'd3, 0, 0, 0);
    rd(2'd1, v); check("R5 edge runs", v, 48'd2);

    // R6 error bit and recovery
    wr(2'd0, 48'h000B);
    rd(2'd2, v); check("R6 error bit set", v, 48'h2);
    wr(2'd1, 48'd9); step(4'd5, 0, 0, 0); step(4'd5, 0, 0, 0);
    rd(2'd1, v); check("R6 frozen", v, 48'd9);
    wr(2'd0, 48'h0003);
    rd(2'd2, v); check("R6 error cleared", v, 48'h0);

    // R7 global enable low
    wr(2'd1, 48'd7);
    eventCount = 4'd5; privLevel = 2'd1;
    repeat (3) @(negedge clk);
    eventCount = '0;
    rd(2'd1, v); check("R7 global enable low", v, 48'd7);

    // R9 abort restores, even with an increment in the abort cycle
    wr(2'd0, 48'h0023); wr(2'd1, 48'd100);
    step(4'd0, 0, 0, 0);
    step(4'd5, 1, 0, 0); step(4'd5, 1, 0, 0); step(4'd5, 1, 0, 0);
    rd(2'd1, v); check("R9 inside txn", v, 48'd115);
    step(4'd5, 1, 1, 0);
    inTxn = 1'b0;
    rd(2'd1, v); check("R9 abort restore", v, 48'd100);
    @(negedge clk);

    // R9 commit discards checkpoint
    wr(2'd1, 48'd200);
    step(4'd2, 1, 0, 0); step(4'd2, 1, 0, 0);
    step(4'd0, 1, 0, 1);
    step(4'd0, 0, 0, 0);
    step(4'd0, 0, 1, 0);
    rd(2'd1, v); check("R9 abort after commit", v, 48'd204);

    // R9 checkpoint flag clear
    wr(2'd0, 48'h0003); wr(2'd1, 48'd300);
    step(4'd4, 1, 0, 0); step(4'd4, 1, 0, 0);
    step(4'd0, 1, 1, 0);
    inTxn = 1'b0;
    rd(2'd1, v); check("R9 no checkpoint flag", v, 48'd308);
    @(negedge clk);

    // R10 wrap and sticky flag
    wr(2'd1, 48'hFFFF_FFFF_FFFE);
    step(4'd3, 0, 0, 0);
    rd(2'd1, v); check("R10 wrapped value", v, 48'd1);
    rd(2'd2, v); check("R10 flag set", v, 48'h1);
    @(negedge clk);
    rd(2'd2, v); check("R10 flag sticky", v, 48'h1);
    wr(2'd2, 48'h1);
    rd(2'd2, v); check("R10 flag cleared", v, 48'h0);
    wr(2'd1, 48'hFFFF_FFFF_FFFF);
    globalEn = 1'b1; privLevel = 2'd1; eventCount = 4'd1;
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 48'h1;
    @(negedge clk);
    globalEn = 1'b0; eventCount = '0; regWrEn = 1'b0; regWrData = '0;
    rd(2'd2, v); check("R10 set beats clear", v, 48'h1);
    rd(2'd1, v); check("R10 wrap to zero", v, 48'h0);

    // R11 preset wins over increment, config masking
    globalEn = 1'b1; privLevel = 2'd1; eventCount = 4'd5;
    wr(2'd1, 48'd50);
    globalEn = 1'b0; eventCount = '0;
    rd(2'd1, v); check("R11 preset priority", v, 48'd50);
    wr(2'd0, 48'hFFFF_FFFF_FFFF);
    rd(2'd0, v); check("R11 config masking", v, 48'hFF3F);
    rd(2'd3, v); check("R11 unmapped address", v, 48'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule